// File: doc/BRIEF.md
# Trap Entry Unit

This block carries out the state changes a processor core makes when it takes an exception or an interrupt. The pipeline presents a trap on a one-cycle strobe. With it come a raw cause code and an interrupt flag, a source kind and access type for the faulting operation, the program counter of the trapping instruction, the faulting address, the current privilege level, the two delegation masks, both trap vectors and the current status word. On the clock edge that samples the strobe, the unit works out the final cause number. It decides whether the trap goes to the supervisor level or the machine level. It then writes the cause, return-PC and fault-address registers of that level, pushes the interrupt-enable and privilege stack in the status word, and loads the new program counter and privilege.

The final cause comes from one of three paths. The first is a raw code, where an environment call is renumbered by the privilege it came from. The second is a failed address translation, which becomes a page fault or an access fault depending on whether paging is active. The third is a misaligned access, numbered by access type. The unit holds both levels' trap registers and keeps every value until the next strobe.

Top module: `trap_entry`

## Requirements
- R1: After a synchronous reset every register output is zero, the privilege output is machine (3) and the completion flag is low.
- R2: For a non-interrupt raw-source trap with code 8, the reported cause is 8 plus the current privilege (U=0, S=1, H=2, M=3), giving 8, 9, 10 or 11. Any other raw code passes through unchanged.
- R3: An interrupt writes a cause whose most significant bit is set and whose low bits carry the given code. The source kind is ignored for interrupts.
- R4: A trap goes to supervisor level only when the current privilege is U or S and the mask bit indexed by the final cause code is set. That mask is the interrupt delegation mask for interrupts and the exception delegation mask for exceptions. Every other trap goes to machine level.
- R5: Supervisor entry loads the PC from the supervisor vector and writes the supervisor cause and return-PC registers. In the status word it copies SIE (bit 1) into SPIE (bit 5), writes privilege bit 0 into SPP (bit 8) and clears SIE. The new privilege is 1. Machine trap registers are untouched.
- R6: Machine entry loads the PC from the machine vector and writes the machine cause and return-PC registers. In the status word it copies MIE (bit 3) into MPIE (bit 7), writes the privilege into MPP (bits 12:11) and clears MIE. The new privilege is 3. Supervisor trap registers are untouched. All other status bits pass through from the input.
- R7: The fault-address register of the chosen level takes the fault address only for exception causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. For any other cause, and for every interrupt, it keeps its value.
- R8: A translation-fault source (kind 1) yields 12, 13 or 15 for fetch, load or store (access 0, 1, 2; 3 counts as store) when paging is on, and 1, 5 or 7 when paging is off.
- R9: A misaligned source (kind 2) yields 0, 4 or 6 for fetch, load or store. Kinds 0 and 3 select the raw code.
- R10: All updates commit on the edge that samples the strobe. The completion flag is high for exactly the following cycle. Without a strobe no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_i | input | 1 | One-cycle trap strobe |
| irq_i | input | 1 | Trap is an interrupt |
| src_i | input | 2 | Source kind: 0 raw, 1 translation fault, 2 misaligned |
| acc_i | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| paging_i | input | 1 | Address translation is active |
| code_i | input | 6 | Raw cause code |
| priv_i | input | 2 | Current privilege |
| epc_i | input | XLEN | PC of the trapping instruction |
| fault_addr_i | input | XLEN | Faulting address |
| edeleg_i | input | XLEN | Exception delegation mask |
| ideleg_i | input | XLEN | Interrupt delegation mask |
| svec_i | input | XLEN | Supervisor trap vector |
| mvec_i | input | XLEN | Machine trap vector |
| status_i | input | XLEN | Current status word |
| pc_o | output | XLEN | New program counter |
| priv_o | output | 2 | New privilege |
| status_o | output | XLEN | Updated status word |
| scause_o | output | XLEN | Supervisor cause register |
| sepc_o | output | XLEN | Supervisor return-PC register |
| stval_o | output | XLEN | Supervisor fault-address register |
| mcause_o | output | XLEN | Machine cause register |
| mepc_o | output | XLEN | Machine return-PC register |
| mtval_o | output | XLEN | Machine fault-address register |
| done_o | output | 1 | Completion pulse, one cycle after the strobe |

## Verification
The bench sets the two delegation masks to disagree on the same bit, so a design that indexes the wrong mask sends the trap to the wrong level. It raises a delegated exception from hypervisor and machine privilege; a design that delegates from any level would land those in supervisor mode. It covers environment calls from every privilege, both fault mappings with paging on and off, and interrupts and non-address causes that must leave the fault-address registers alone. A design that writes the fault address unconditionally shows a changed value there. An idle stretch with moving inputs then exposes any register that updates without a strobe.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int CODE_W = 6;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_H = 2'd2,
        PRIV_M = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        SRC_RAW   = 2'd0,
        SRC_XLATE = 2'd1,
        SRC_MISAL = 2'd2,
        SRC_RSVD  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // status word bit positions (decoded by neighbouring logic)
    localparam int ST_SIE    = 1;
    localparam int ST_MIE    = 3;
    localparam int ST_SPIE   = 5;
    localparam int ST_MPIE   = 7;
    localparam int ST_SPP    = 8;
    localparam int ST_MPP_LO = 11;

    // cause numbers
    localparam int C_MISAL_F = 0;
    localparam int C_ACCF_F  = 1;
    localparam int C_MISAL_L = 4;
    localparam int C_ACCF_L  = 5;
    localparam int C_MISAL_S = 6;
    localparam int C_ACCF_S  = 7;
    localparam int C_ENVCALL = 8;
    localparam int C_PGF_F   = 12;
    localparam int C_PGF_L   = 13;
    localparam int C_PGF_S   = 15;

    typedef struct packed {
        logic              irq;
        logic [CODE_W-1:0] code;
        logic              tval_en;
    } cause_t;

    function automatic logic carries_addr(input logic [CODE_W-1:0] code);
        case (int'(code))
            C_MISAL_F, C_ACCF_F, C_MISAL_L, C_ACCF_L,
            C_MISAL_S, C_ACCF_S, C_PGF_F, C_PGF_L, C_PGF_S: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/trap_cause_fix.sv
module trap_cause_fix
    import trap_pkg::*;
(
    input  logic              irq_i,
    input  src_e              src_i,
    input  acc_e              acc_i,
    input  logic              paging_i,
    input  logic [CODE_W-1:0] code_i,
    input  priv_e             priv_i,
    output cause_t            cause_o
);

    logic [CODE_W-1:0] code_sel;

    always_comb begin
        code_sel = code_i;
        if (!irq_i) begin
            case (src_i)
                SRC_XLATE: begin
                    if (paging_i) begin
                        case (acc_i)
                            ACC_FETCH: code_sel = CODE_W'(C_PGF_F);
                            ACC_LOAD:  code_sel = CODE_W'(C_PGF_L);
                            default:   code_sel = CODE_W'(C_PGF_S);
                        endcase
                    end else begin
                        case (acc_i)
                            ACC_FETCH: code_sel = CODE_W'(C_ACCF_F);
                            ACC_LOAD:  code_sel = CODE_W'(C_ACCF_L);
                            default:   code_sel = CODE_W'(C_ACCF_S);
                        endcase
                    end
                end
                SRC_MISAL: begin
                    case (acc_i)
                        ACC_FETCH: code_sel = CODE_W'(C_MISAL_F);
                        ACC_LOAD:  code_sel = CODE_W'(C_MISAL_L);
                        default:   code_sel = CODE_W'(C_MISAL_S);
                    endcase
                end
                default: begin
                    if (int'(code_i) == C_ENVCALL)
                        code_sel = CODE_W'(C_ENVCALL) + CODE_W'(priv_i);
                    else
                        code_sel = code_i;
                end
            endcase
        end
    end

    always_comb begin
        cause_o.irq     = irq_i;
        cause_o.code    = code_sel;
        cause_o.tval_en = !irq_i && carries_addr(code_sel);
    end

endmodule

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  cause_t            cause_i,
    input  priv_e             priv_i,
    input  logic [XLEN-1:0]   edeleg_i,
    input  logic [XLEN-1:0]   ideleg_i,
    output logic              to_super_o
);

    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] shifted;
    logic            low_priv;

    always_comb begin
        mask       = cause_i.irq ? ideleg_i : edeleg_i;
        shifted    = mask >> cause_i.code;
        low_priv   = (priv_i == PRIV_U) || (priv_i == PRIV_S);
        to_super_o = low_priv && shifted[0];
    end

endmodule

// File: rtl/trap_status_stack.sv
module trap_status_stack
    import trap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] status_i,
    input  priv_e           priv_i,
    input  logic            to_super_i,
    output logic [XLEN-1:0] status_o
);

    always_comb begin
        status_o = status_i;
        if (to_super_i) begin
            status_o[ST_SPIE] = status_i[ST_SIE];
            status_o[ST_SPP]  = priv_i[0];
            status_o[ST_SIE]  = 1'b0;
        end else begin
            status_o[ST_MPIE]        = status_i[ST_MIE];
            status_o[ST_MPP_LO +: 2] = priv_i;
            status_o[ST_MIE]         = 1'b0;
        end
    end

endmodule

// File: rtl/trap_entry.sv
module trap_entry
    import trap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_i,
    input  logic              irq_i,
    input  logic [1:0]        src_i,
    input  logic [1:0]        acc_i,
    input  logic              paging_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [1:0]        priv_i,
    input  logic [XLEN-1:0]   epc_i,
    input  logic [XLEN-1:0]   fault_addr_i,
    input  logic [XLEN-1:0]   edeleg_i,
    input  logic [XLEN-1:0]   ideleg_i,
    input  logic [XLEN-1:0]   svec_i,
    input  logic [XLEN-1:0]   mvec_i,
    input  logic [XLEN-1:0]   status_i,
    output logic [XLEN-1:0]   pc_o,
    output logic [1:0]        priv_o,
    output logic [XLEN-1:0]   status_o,
    output logic [XLEN-1:0]   scause_o,
    output logic [XLEN-1:0]   sepc_o,
    output logic [XLEN-1:0]   stval_o,
    output logic [XLEN-1:0]   mcause_o,
    output logic [XLEN-1:0]   mepc_o,
    output logic [XLEN-1:0]   mtval_o,
    output logic              done_o
);

    localparam int PAD_W = XLEN - 1 - CODE_W;

    priv_e           cur_priv;
    cause_t          cause;
    logic            to_super;
    logic [XLEN-1:0] next_status;
    logic [XLEN-1:0] cause_word;

    assign cur_priv = priv_e'(priv_i);

    trap_cause_fix u_fix (
        .irq_i    (irq_i),
        .src_i    (src_e'(src_i)),
        .acc_i    (acc_e'(acc_i)),
        .paging_i (paging_i),
        .code_i   (code_i),
        .priv_i   (cur_priv),
        .cause_o  (cause)
    );

    trap_route #(.XLEN(XLEN)) u_route (
        .cause_i    (cause),
        .priv_i     (cur_priv),
        .edeleg_i   (edeleg_i),
        .ideleg_i   (ideleg_i),
        .to_super_o (to_super)
    );

    trap_status_stack #(.XLEN(XLEN)) u_stack (
        .status_i   (status_i),
        .priv_i     (cur_priv),
        .to_super_i (to_super),
        .status_o   (next_status)
    );

    assign cause_word = {cause.irq, {PAD_W{1'b0}}, cause.code};

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_o     <= '0;
            priv_o   <= PRIV_M;
            status_o <= '0;
            scause_o <= '0;
            sepc_o   <= '0;
            stval_o  <= '0;
            mcause_o <= '0;
            mepc_o   <= '0;
            mtval_o  <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= trap_i;
            if (trap_i) begin
                status_o <= next_status;
                if (to_super) begin
                    pc_o     <= svec_i;
                    priv_o   <= PRIV_S;
                    scause_o <= cause_word;
                    sepc_o   <= epc_i;
                    if (cause.tval_en) stval_o <= fault_addr_i;
                end else begin
                    pc_o     <= mvec_i;
                    priv_o   <= PRIV_M;
                    mcause_o <= cause_word;
                    mepc_o   <= epc_i;
                    if (cause.tval_en) mtval_o <= fault_addr_i;
                end
            end
        end
    end

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        trap_i |=> done_o); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !trap_i |=> !done_o); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !trap_i |=> ($stable(pc_o) && $stable(priv_o) && $stable(status_o)
                     && $stable(mcause_o) && $stable(scause_o))); // R10
    AST_MACHINE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (trap_i && priv_i == 2'd3) |=> (priv_o == 2'd3)); // R4
    AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
        (trap_i && irq_i) |=> ((priv_o == 2'd1) ? scause_o[XLEN-1] : mcause_o[XLEN-1])); // R3
    AST_VECTOR_PICK: assert property (@(posedge clk) disable iff (rst)
        trap_i |=> (pc_o == ((priv_o == 2'd1) ? $past(svec_i) : $past(mvec_i)))); // R5
    AST_EPC_SAVED: assert property (@(posedge clk) disable iff (rst)
        trap_i |=> (((priv_o == 2'd1) ? sepc_o : mepc_o) == $past(epc_i))); // R6
    AST_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        trap_i |=> !((priv_o == 2'd1) ? status_o[ST_SIE] : status_o[ST_MIE])); // R5
    AST_IRQ_NO_TVAL: assert property (@(posedge clk) disable iff (rst)
        (trap_i && irq_i) |=> ($stable(stval_o) && $stable(mtval_o))); // R7

endmodule

// File: tb/trap_entry_bench.sv
module trap_entry_bench;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;
    localparam int WATCHDOG = 20000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            trap_i = 1'b0;
    logic            irq_i = 1'b0;
    logic [1:0]      src_i = '0;
    logic [1:0]      acc_i = '0;
    logic            paging_i = 1'b0;
    logic [5:0]      code_i = '0;
    logic [1:0]      priv_i = '0;
    logic [XLEN-1:0] epc_i = '0, fault_addr_i = '0, edeleg_i = '0, ideleg_i = '0;
    logic [XLEN-1:0] svec_i = '0, mvec_i = '0, status_i = '0;
    logic [XLEN-1:0] pc_o, status_o, scause_o, sepc_o, stval_o, mcause_o, mepc_o, mtval_o;
    logic [1:0]      priv_o;
    logic            done_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry #(.XLEN(XLEN)) u_trap_entry (
        .clk(clk), .rst(rst), .trap_i(trap_i), .irq_i(irq_i), .src_i(src_i),
        .acc_i(acc_i), .paging_i(paging_i), .code_i(code_i), .priv_i(priv_i),
        .epc_i(epc_i), .fault_addr_i(fault_addr_i), .edeleg_i(edeleg_i),
        .ideleg_i(ideleg_i), .svec_i(svec_i), .mvec_i(mvec_i), .status_i(status_i),
        .pc_o(pc_o), .priv_o(priv_o), .status_o(status_o), .scause_o(scause_o),
        .sepc_o(sepc_o), .stval_o(stval_o), .mcause_o(mcause_o), .mepc_o(mepc_o),
        .mtval_o(mtval_o), .done_o(done_o)
    );

    typedef struct {
        logic [XLEN-1:0] pc, status, scause, sepc, stval, mcause, mepc, mtval;
        logic [1:0]      priv;
        string           tag;
    } exp_t;

    exp_t q[$];
    exp_t model;
    int checks = 0;
    int errors = 0;
    bit ended = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int final_code(input bit irq, input int src, input int acc,
                                      input bit paging, input int code, input int priv);
        int a;
        a = (acc > 2) ? 2 : acc;
        if (irq) return code;
        if (src == 1) begin
            if (paging) return (a == 0) ? 12 : (a == 1) ? 13 : 15;
            return (a == 0) ? 1 : (a == 1) ? 5 : 7;
        end
        if (src == 2) return a * 2 + ((a == 0) ? 0 : 2);
        if (code == 8) return 8 + priv;
        return code;
    endfunction

    task automatic do_trap(input bit irq, input int src, input int acc, input bit paging,
                           input int code, input int priv, input logic [XLEN-1:0] edel,
                           input logic [XLEN-1:0] idel, input logic [XLEN-1:0] st,
                           input string tag);
        int fc;
        bit sup, tv;
        logic [XLEN-1:0] cw, ns, e, f;
        e = 64'h8000_0000 + 64'(checks * 4 + priv * 16 + code);
        f = 64'hdead_0000 + 64'(code * 256 + src * 16 + acc);
        fc = final_code(irq, src, acc, paging, code, priv);
        sup = (priv <= 1) && ((irq ? idel[fc] : edel[fc]) == 1'b1);
        tv = !irq && (fc inside {0, 1, 4, 5, 6, 7, 12, 13, 15});
        cw = {irq, 57'd0, 6'(fc)};
        ns = st;
        if (sup) begin
            ns[5] = st[1]; ns[8] = priv[0]; ns[1] = 1'b0;
            model.pc = svec_i; model.priv = 2'd1; model.scause = cw; model.sepc = e;
            if (tv) model.stval = f;
        end else begin
            ns[7] = st[3]; ns[12:11] = 2'(priv); ns[3] = 1'b0;
            model.pc = mvec_i; model.priv = 2'd3; model.mcause = cw; model.mepc = e;
            if (tv) model.mtval = f;
        end
        model.status = ns;
        model.tag = tag;
        q.push_back(model);
        @(negedge clk);
        trap_i = 1'b1; irq_i = irq; src_i = 2'(src); acc_i = 2'(acc); paging_i = paging;
        code_i = 6'(code); priv_i = 2'(priv); edeleg_i = edel; ideleg_i = idel;
        status_i = st; epc_i = e; fault_addr_i = f;
        @(negedge clk);
        trap_i = 1'b0;
    endtask

    // monitor: compares each completion against the scoreboard head
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (q.size() == 0) begin
                chk(1'b0, "R10", "unexpected done", 64'(done_o), 64'd0);
            end else begin
                exp_t x;
                x = q.pop_front();
                chk(pc_o == x.pc, "R5/R6", {x.tag, " pc"}, pc_o, x.pc);
                chk(priv_o == x.priv, "R4", {x.tag, " priv"}, 64'(priv_o), 64'(x.priv));
                chk(status_o == x.status, "R5/R6", {x.tag, " status"}, status_o, x.status);
                chk(scause_o == x.scause, x.tag, "scause", scause_o, x.scause);
                chk(mcause_o == x.mcause, x.tag, "mcause", mcause_o, x.mcause);
                chk(sepc_o == x.sepc, "R5", {x.tag, " sepc"}, sepc_o, x.sepc);
                chk(mepc_o == x.mepc, "R6", {x.tag, " mepc"}, mepc_o, x.mepc);
                chk(stval_o == x.stval, "R7", {x.tag, " stval"}, stval_o, x.stval);
                chk(mtval_o == x.mtval, "R7", {x.tag, " mtval"}, mtval_o, x.mtval);
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!ended) begin
            ended = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] snap_pc, snap_st, snap_mc, snap_sc, snap_mt, snap_stv;
        model = '{pc: '0, status: '0, scause: '0, sepc: '0, stval: '0,
                  mcause: '0, mepc: '0, mtval: '0, priv: 2'd3, tag: ""};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(pc_o == 0 && status_o == 0 && mcause_o == 0 && scause_o == 0, "R1", "regs", pc_o, 0);
        chk(priv_o == 2'd3, "R1", "priv", 64'(priv_o), 64'd3);
        chk(done_o == 1'b0, "R1", "done", 64'(done_o), 64'd0);

        svec_i = 64'h0000_0000_0004_0000; mvec_i = 64'h0000_0000_0008_0000;
        do_trap(0, 0, 0, 0, 8, 3, '1, '0, 64'h0000_0000_0000_000a, "R2 ecall M");
        do_trap(0, 0, 0, 0, 8, 0, 64'h100, '0, 64'h0000_0000_0000_0002, "R2 ecall U R5");
        do_trap(0, 0, 0, 0, 8, 1, 64'h100, '0, 64'h0000_0000_0000_0008, "R2 ecall S R6");
        do_trap(0, 0, 0, 0, 8, 2, '1, '0, 64'h0000_0000_0000_0000, "R2 ecall H R4");
        svec_i = 64'h0000_0000_0004_1000;
        do_trap(1, 1, 0, 1, 5, 0, 64'h0, 64'h20, 64'h0000_0000_0000_0002, "R3 irq deleg");
        do_trap(1, 2, 0, 0, 7, 1, 64'h80, 64'h0, 64'h0000_0000_0000_000a, "R3 irq to M R4");
        do_trap(0, 0, 0, 0, 2, 3, '1, '1, 64'h0000_0000_0000_0008, "R4 from M R7");
        do_trap(0, 1, 1, 1, 0, 3, '0, '0, 64'h0000_0000_0000_0008, "R8 load pf");
        do_trap(0, 1, 2, 0, 0, 1, '0, '0, 64'h0000_0000_0000_0002, "R8 store af");
        mvec_i = 64'h0000_0000_0009_0000;
        do_trap(0, 1, 0, 1, 0, 0, 64'h1000, '0, 64'h0000_0000_0000_0002, "R8 fetch pf R5");
        do_trap(0, 1, 3, 1, 0, 0, '0, '0, 64'h0000_0000_0000_0000, "R8 rsvd acc");
        do_trap(0, 2, 2, 0, 0, 1, 64'h40, '0, 64'h0000_0000_0000_0022, "R9 mis store");
        do_trap(0, 2, 0, 0, 0, 3, '0, '0, 64'h0000_0000_0000_0008, "R9 mis fetch");
        do_trap(0, 3, 1, 1, 3, 0, 64'h8, '0, 64'h0000_0000_0000_0002, "R9 rsvd src R7");
        do_trap(1, 0, 0, 0, 9, 1, '1, '0, 64'h0000_0000_0000_000a, "R3 irq no tval R7");
        repeat (3) @(negedge clk);

        // R10 idle: inputs move, nothing may change
        snap_pc = pc_o; snap_st = status_o; snap_mc = mcause_o; snap_sc = scause_o;
        snap_mt = mtval_o; snap_stv = stval_o;
        for (int i = 0; i < 5; i++) begin
            mvec_i = mvec_i + 64'h100; svec_i = svec_i + 64'h100;
            status_i = ~status_i; fault_addr_i = fault_addr_i + 1; code_i = 6'(i + 8);
            @(negedge clk);
            chk(done_o == 1'b0, "R10", "idle done", 64'(done_o), 64'd0);
            chk(pc_o == snap_pc && status_o == snap_st && mcause_o == snap_mc &&
                scause_o == snap_sc && mtval_o == snap_mt && stval_o == snap_stv,
                "R10", "idle hold", pc_o, snap_pc);
        end
        chk(q.size() == 0, "R10", "pending items", 64'(q.size()), 64'd0);
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule